// File: doc/BRIEF.md
# Speculative Branch Tag Tracker

This block hands out tags to predicted branches in an out-of-order front end. Every instruction fetched after a predicted branch travels with that branch's tag, so the tag names one speculated basic block. When the branch is allocated, the block stores three things: the predicted direction, the branch target and the fall-through (sequential) address. The redirect address on a wrong guess is later taken from these saved values.

Each tag is resolved later by the execution side. A correct resolution releases the tag alone, and the instructions under it stop being speculative. A wrong resolution releases the tag together with every tag allocated after it. One cycle later the block pulses a per-tag flush mask for the downstream buffers, along with a redirect strobe and the corrected fetch address. If the branch was predicted taken, that address is the saved sequential address. If it was predicted not-taken, it is the saved target. Allocation then picks up again at the tag that was wrong.

Top module: `spec_tag_tracker`

## Requirements
- R1: After reset, `busy_mask` is 0, `alloc_tag` is 0, `tags_full` is 0, `alloc_ready` is 1 and `flush_valid` is 0.
- R2: Accepted allocations receive tags in circular order 0,1,2,3,0. `alloc_tag` shows the tag that the next allocation will get. The matching `busy_mask` bit is set after the accepting clock edge. Bit i of `busy_mask` and of `flush_mask` refers to tag i.
- R3: `tags_full` is 1 whenever the tag at the allocation pointer is still busy, for example when all four tags are busy. While it is 1, `alloc_ready` is 0 and `alloc_valid` has no effect on `busy_mask`.
- R4: A correct resolution (`resolve_mispredict`=0) of a busy tag clears only that tag's busy bit and causes no flush. Resolving an older tag never clears a younger one, and resolutions may arrive in any order.
- R5: A misprediction of a busy tag makes `flush_valid` 1 for exactly one cycle, on the cycle after the resolve. `flush_mask` then holds the mispredicted tag plus every busy tag allocated after it, with age following allocation order across pointer wrap. Those bits leave `busy_mask` at the same edge, and older tags stay busy.
- R6: `redirect_pc` is valid while `flush_valid` is 1. It equals the sequential address saved for the mispredicted tag if that branch was predicted taken, and the saved target address if it was predicted not-taken.
- R7: In a cycle where `resolve_valid` and `resolve_mispredict` are both 1, `alloc_ready` is 0 and a requested allocation is dropped.
- R8: After a misprediction, the next allocation receives the tag number that was mispredicted.
- R9: A resolution naming a tag that is not busy is ignored: no flush and no change to `busy_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | A predicted branch requests a tag |
| alloc_pred_taken | input | 1 | Predicted direction of that branch (1 = taken) |
| alloc_target_pc | input | PC_W | Branch target address |
| alloc_seq_pc | input | PC_W | Sequential (fall-through) address |
| alloc_ready | output | 1 | Allocation is accepted this cycle |
| alloc_tag | output | TAG_W | Tag given to the allocation this cycle |
| tags_full | output | 1 | Next tag in circular order is still in use |
| resolve_valid | input | 1 | A branch outcome is reported |
| resolve_tag | input | TAG_W | Tag of the resolved branch |
| resolve_mispredict | input | 1 | 1 = prediction was wrong |
| busy_mask | output | NUM_TAGS | Tags currently speculative |
| flush_valid | output | 1 | One-cycle recovery strobe |
| flush_mask | output | NUM_TAGS | Tags to squash |
| redirect_pc | output | PC_W | Corrected fetch address |

## Verification
A corrupted age relation shows up in the flush mask one cycle after a misprediction. Either it leaves out a younger tag, or it squashes an older one that stays busy. The bench therefore mispredicts both before and after the allocation pointer wraps. A wrong busy or pointer state shows up in `alloc_tag`, `tags_full` or `busy_mask` on the very next cycle. A swapped path choice shows up in `redirect_pc` during the flush strobe, so both predicted directions are mispredicted.

// File: rtl/spec_tag_pkg.sv
// Shared types for the speculative branch tag tracker.
// Assumes nothing beyond a two-valued predicted direction.
package spec_tag_pkg;

    typedef enum logic {
        DIR_NOT_TAKEN = 1'b0,
        DIR_TAKEN     = 1'b1
    } pred_dir_e;

endpackage

// File: rtl/stt_alloc_ctrl.sv
// Allocation pointer and busy vector.
// Hands out tags in circular order, stalls when the slot at the pointer is
// busy, clears tags on correct resolution or flush, and rewinds the pointer
// to a mispredicted tag. Assumes kill_mask and free_mask hold busy tags only.
module stt_alloc_ctrl #(
    parameter int NUM_TAGS = 4,
    localparam int TAG_W = $clog2(NUM_TAGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alloc_req,
    input  logic                block_alloc,
    input  logic [NUM_TAGS-1:0] free_mask,
    input  logic [NUM_TAGS-1:0] kill_mask,
    input  logic                rewind,
    input  logic [TAG_W-1:0]    rewind_tag,
    output logic [NUM_TAGS-1:0] busy_o,
    output logic [TAG_W-1:0]    ptr_o,
    output logic                full_o,
    output logic                ready_o,
    output logic                accept_o
);

    localparam logic [TAG_W-1:0] LAST_TAG = TAG_W'(NUM_TAGS - 1);

    logic [NUM_TAGS-1:0] busy_q;
    logic [TAG_W-1:0]    ptr_q;
    logic [NUM_TAGS-1:0] set_mask;
    logic [TAG_W-1:0]    ptr_inc;

    // Full when the next circular slot is still held; mispredict blocks allocation.
    always_comb begin
        full_o   = busy_q[ptr_q];
        ready_o  = !full_o && !block_alloc;
        accept_o = alloc_req && ready_o;
        set_mask = accept_o ? (NUM_TAGS'(1) << ptr_q) : '0;
        ptr_inc  = (ptr_q == LAST_TAG) ? '0 : ptr_q + TAG_W'(1);
    end

    // Busy vector update: clear freed and killed tags, set the new one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
        end else begin
            busy_q <= (busy_q & ~free_mask & ~kill_mask) | set_mask;
        end
    end

    // Pointer: rewind on misprediction, otherwise advance on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (rewind) begin
            ptr_q <= rewind_tag;
        end else if (accept_o) begin
            ptr_q <= ptr_inc;
        end
    end

    assign busy_o = busy_q;
    assign ptr_o  = ptr_q;

endmodule

// File: rtl/stt_age_matrix.sv
// Relative age of the tags.
// older_q[i][j] = 1 means tag i was allocated before tag j while both were
// live. The row and column of a tag are rewritten when it is allocated, so
// bits left over from earlier owners of a slot never matter. Callers gate
// the query result with the busy vector.
module stt_age_matrix #(
    parameter int NUM_TAGS = 4,
    localparam int TAG_W = $clog2(NUM_TAGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept,
    input  logic [TAG_W-1:0]    new_tag,
    input  logic [NUM_TAGS-1:0] live_mask,
    input  logic [TAG_W-1:0]    query_tag,
    output logic [NUM_TAGS-1:0] younger_o
);

    logic [NUM_TAGS-1:0] older_q [NUM_TAGS];

    for (genvar gi = 0; gi < NUM_TAGS; gi++) begin : g_row
        for (genvar gj = 0; gj < NUM_TAGS; gj++) begin : g_col
            if (gi == gj) begin : g_diag
                // A tag is never older than itself.
                always_ff @(posedge clk) begin
                    older_q[gi][gj] <= 1'b0;
                end
            end else begin : g_off
                // On allocation of gj, every live gi becomes older than it;
                // on allocation of gi, it is older than nothing.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        older_q[gi][gj] <= 1'b0;
                    end else if (accept && (new_tag == TAG_W'(gj))) begin
                        older_q[gi][gj] <= live_mask[gi];
                    end else if (accept && (new_tag == TAG_W'(gi))) begin
                        older_q[gi][gj] <= 1'b0;
                    end
                end
            end
        end
    end

    // Row of the queried tag lists the tags allocated after it.
    always_comb begin
        younger_o = older_q[query_tag];
    end

endmodule

// File: rtl/stt_path_store.sv
// Per-tag storage of predicted direction, target and sequential address.
// Written at allocation; read when that tag mispredicts to pick the
// path that was not followed.
module stt_path_store
    import spec_tag_pkg::*;
#(
    parameter int NUM_TAGS = 4,
    parameter int PC_W     = 32,
    localparam int TAG_W = $clog2(NUM_TAGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_taken,
    input  logic [PC_W-1:0]  wr_target,
    input  logic [PC_W-1:0]  wr_seq,
    input  logic [TAG_W-1:0] rd_tag,
    output logic [PC_W-1:0]  alt_pc_o
);

    pred_dir_e       dir_q    [NUM_TAGS];
    logic [PC_W-1:0] target_q [NUM_TAGS];
    logic [PC_W-1:0] seq_q    [NUM_TAGS];

    for (genvar gt = 0; gt < NUM_TAGS; gt++) begin : g_slot
        // Capture the branch record when this slot is allocated.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dir_q[gt]    <= DIR_NOT_TAKEN;
                target_q[gt] <= '0;
                seq_q[gt]    <= '0;
            end else if (wr_en && (wr_tag == TAG_W'(gt))) begin
                dir_q[gt]    <= wr_taken ? DIR_TAKEN : DIR_NOT_TAKEN;
                target_q[gt] <= wr_target;
                seq_q[gt]    <= wr_seq;
            end
        end
    end

    // The corrected path is the one the prediction did not choose.
    always_comb begin
        if (dir_q[rd_tag] == DIR_TAKEN) begin
            alt_pc_o = seq_q[rd_tag];
        end else begin
            alt_pc_o = target_q[rd_tag];
        end
    end

endmodule

// File: rtl/stt_flush_gen.sv
// Registers the recovery outputs: one-cycle strobe, kill mask and redirect
// address. Assumes kill_mask is zero whenever fire is low.
module stt_flush_gen #(
    parameter int NUM_TAGS = 4,
    parameter int PC_W     = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fire,
    input  logic [NUM_TAGS-1:0] kill_mask,
    input  logic [PC_W-1:0]     alt_pc,
    output logic                flush_valid_o,
    output logic [NUM_TAGS-1:0] flush_mask_o,
    output logic [PC_W-1:0]     redirect_pc_o
);

    // Strobe and mask follow each misprediction by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_valid_o <= 1'b0;
            flush_mask_o  <= '0;
        end else begin
            flush_valid_o <= fire;
            flush_mask_o  <= kill_mask;
        end
    end

    // Redirect address is captured only on a misprediction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_pc_o <= '0;
        end else if (fire) begin
            redirect_pc_o <= alt_pc;
        end
    end

endmodule

// File: rtl/spec_tag_tracker.sv
// Speculative branch tag tracker (top).
// Allocates per-basic-block tags to predicted branches, releases them on
// correct resolution, and on a misprediction squashes the tag and all
// younger tags while redirecting fetch to the unpredicted path.
// Assumes one resolution per cycle and NUM_TAGS >= 2.
module spec_tag_tracker #(
    parameter int NUM_TAGS = 4,
    parameter int PC_W     = 32,
    localparam int TAG_W = $clog2(NUM_TAGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alloc_valid,
    input  logic                alloc_pred_taken,
    input  logic [PC_W-1:0]     alloc_target_pc,
    input  logic [PC_W-1:0]     alloc_seq_pc,
    output logic                alloc_ready,
    output logic [TAG_W-1:0]    alloc_tag,
    output logic                tags_full,
    input  logic                resolve_valid,
    input  logic [TAG_W-1:0]    resolve_tag,
    input  logic                resolve_mispredict,
    output logic [NUM_TAGS-1:0] busy_mask,
    output logic                flush_valid,
    output logic [NUM_TAGS-1:0] flush_mask,
    output logic [PC_W-1:0]     redirect_pc
);

    logic                block_alloc;
    logic                hit_busy;
    logic                mis_hit;
    logic                ok_hit;
    logic [NUM_TAGS-1:0] res_onehot;
    logic [NUM_TAGS-1:0] free_mask;
    logic [NUM_TAGS-1:0] kill_mask;
    logic [NUM_TAGS-1:0] younger;
    logic                accept;
    logic [NUM_TAGS-1:0] busy;
    logic [TAG_W-1:0]    ptr;
    logic [PC_W-1:0]     alt_pc;

    // Decode the resolution against the current busy set.
    always_comb begin
        block_alloc = resolve_valid && resolve_mispredict;
        hit_busy    = busy[resolve_tag];
        mis_hit     = resolve_valid && resolve_mispredict && hit_busy;
        ok_hit      = resolve_valid && !resolve_mispredict && hit_busy;
        res_onehot  = NUM_TAGS'(1) << resolve_tag;
        free_mask   = ok_hit ? res_onehot : '0;
        kill_mask   = mis_hit ? (res_onehot | (younger & busy)) : '0;
    end

    stt_alloc_ctrl #(.NUM_TAGS(NUM_TAGS)) u_alloc (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_req  (alloc_valid),
        .block_alloc(block_alloc),
        .free_mask  (free_mask),
        .kill_mask  (kill_mask),
        .rewind     (mis_hit),
        .rewind_tag (resolve_tag),
        .busy_o     (busy),
        .ptr_o      (ptr),
        .full_o     (tags_full),
        .ready_o    (alloc_ready),
        .accept_o   (accept)
    );

    stt_age_matrix #(.NUM_TAGS(NUM_TAGS)) u_age (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .new_tag  (ptr),
        .live_mask(busy & ~free_mask),
        .query_tag(resolve_tag),
        .younger_o(younger)
    );

    stt_path_store #(.NUM_TAGS(NUM_TAGS), .PC_W(PC_W)) u_paths (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (accept),
        .wr_tag   (ptr),
        .wr_taken (alloc_pred_taken),
        .wr_target(alloc_target_pc),
        .wr_seq   (alloc_seq_pc),
        .rd_tag   (resolve_tag),
        .alt_pc_o (alt_pc)
    );

    stt_flush_gen #(.NUM_TAGS(NUM_TAGS), .PC_W(PC_W)) u_flush (
        .clk          (clk),
        .rst_n        (rst_n),
        .fire         (mis_hit),
        .kill_mask    (kill_mask),
        .alt_pc       (alt_pc),
        .flush_valid_o(flush_valid),
        .flush_mask_o (flush_mask),
        .redirect_pc_o(redirect_pc)
    );

    assign alloc_tag = ptr;
    assign busy_mask = busy;

endmodule

// File: rtl/spec_tag_tracker_chk.sv
// Port-level properties of the tag tracker, attached with bind.
module spec_tag_tracker_chk #(
    parameter int NUM_TAGS = 4,
    parameter int PC_W     = 32,
    localparam int TAG_W = $clog2(NUM_TAGS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                alloc_valid,
    input logic                alloc_ready,
    input logic [TAG_W-1:0]    alloc_tag,
    input logic                tags_full,
    input logic                resolve_valid,
    input logic                resolve_mispredict,
    input logic [NUM_TAGS-1:0] busy_mask,
    input logic                flush_valid,
    input logic [NUM_TAGS-1:0] flush_mask,
    input logic [PC_W-1:0]     redirect_pc
);

    // R2
    alloc_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_ready) |=> busy_mask[$past(alloc_tag)]);

    // R3
    full_blocks_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tags_full |-> !alloc_ready);

    // R4
    correct_no_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resolve_valid && !resolve_mispredict) |=> !flush_valid);

    // R5
    flush_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> ((flush_mask & busy_mask) == '0));

    // R5
    flush_was_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> ((flush_mask & $past(busy_mask)) == flush_mask && flush_mask != '0));

    // R5
    flush_needs_mispredict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> $past(resolve_valid && resolve_mispredict));

    // R7
    mispredict_blocks_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resolve_valid && resolve_mispredict) |-> !alloc_ready);

endmodule

bind spec_tag_tracker spec_tag_tracker_chk #(.NUM_TAGS(NUM_TAGS), .PC_W(PC_W)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .alloc_valid       (alloc_valid),
    .alloc_ready       (alloc_ready),
    .alloc_tag         (alloc_tag),
    .tags_full         (tags_full),
    .resolve_valid     (resolve_valid),
    .resolve_mispredict(resolve_mispredict),
    .busy_mask         (busy_mask),
    .flush_valid       (flush_valid),
    .flush_mask        (flush_mask),
    .redirect_pc       (redirect_pc)
);

// File: tb/tb_spec_tag_tracker.sv
`timescale 1ns/1ps
// Directed bench for the tag tracker; each task drives and checks one scenario.
module tb_spec_tag_tracker;

    localparam int NT   = 4;
    localparam int PCW  = 32;
    localparam int TW   = 2;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           alloc_valid;
    logic           alloc_pred_taken;
    logic [PCW-1:0] alloc_target_pc;
    logic [PCW-1:0] alloc_seq_pc;
    logic           alloc_ready;
    logic [TW-1:0]  alloc_tag;
    logic           tags_full;
    logic           resolve_valid;
    logic [TW-1:0]  resolve_tag;
    logic           resolve_mispredict;
    logic [NT-1:0]  busy_mask;
    logic           flush_valid;
    logic [NT-1:0]  flush_mask;
    logic [PCW-1:0] redirect_pc;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    spec_tag_tracker #(.NUM_TAGS(NT), .PC_W(PCW)) dut (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        alloc_valid = 0; alloc_pred_taken = 0; alloc_target_pc = '0; alloc_seq_pc = '0;
        resolve_valid = 0; resolve_tag = '0; resolve_mispredict = 0;
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
        idle();
    endtask

    // Allocate one branch, checking the tag it receives.
    task automatic alloc(input bit taken, input logic [PCW-1:0] tgt, input logic [PCW-1:0] seq,
                         input logic [TW-1:0] exp_tag);
        alloc_valid = 1; alloc_pred_taken = taken; alloc_target_pc = tgt; alloc_seq_pc = seq;
        #1;
        chk(alloc_ready && alloc_tag == exp_tag, "R2 tag order", alloc_tag, exp_tag);
        step();
    endtask

    task automatic resolve(input logic [TW-1:0] t, input bit mis);
        resolve_valid = 1; resolve_tag = t; resolve_mispredict = mis;
        step();
    endtask

    task automatic t_reset();
        chk(busy_mask == 0, "R1 busy", busy_mask, 0);
        chk(alloc_tag == 0 && !tags_full && alloc_ready, "R1 alloc", {alloc_tag, tags_full, alloc_ready}, 1);
        chk(!flush_valid, "R1 flush", flush_valid, 0);
    endtask

    task automatic t_fill();
        alloc(1, 32'h100, 32'h004, 0);
        alloc(0, 32'h200, 32'h014, 1);
        alloc(1, 32'h300, 32'h024, 2);
        chk(busy_mask == 4'b0111 && !tags_full, "R2 busy", busy_mask, 4'b0111);
        alloc(0, 32'h400, 32'h034, 3);
        chk(busy_mask == 4'b1111, "R2 busy all", busy_mask, 4'b1111);
        chk(tags_full && alloc_tag == 0, "R3 full", {tags_full, alloc_tag}, 4'b100);
        alloc_valid = 1; #1;
        chk(!alloc_ready, "R3 ready low", alloc_ready, 0);
        step();
        chk(busy_mask == 4'b1111, "R3 ignored", busy_mask, 4'b1111);
    endtask

    task automatic t_ooo_free();
        resolve(2, 0);
        chk(busy_mask == 4'b1011 && !flush_valid, "R4 free 2", {flush_valid, busy_mask}, 4'b1011);
        resolve(0, 0);
        chk(busy_mask == 4'b1010, "R4 older keeps younger", busy_mask, 4'b1010);
        chk(!tags_full && alloc_tag == 0, "R3 not full", {tags_full, alloc_tag}, 0);
        resolve(3, 0);
        resolve(1, 0);
        chk(busy_mask == 0, "R4 all free", busy_mask, 0);
    endtask

    task automatic t_mispredict();
        alloc(1, 32'hA000, 32'hA004, 0);
        alloc(0, 32'hB000, 32'hB004, 1);
        alloc(1, 32'hC000, 32'hC004, 2);
        alloc(0, 32'hD000, 32'hD004, 3);
        resolve(1, 1);
        chk(flush_valid && flush_mask == 4'b1110, "R5 mask", flush_mask, 4'b1110);
        chk(busy_mask == 4'b0001, "R5 older kept", busy_mask, 4'b0001);
        chk(redirect_pc == 32'hB000, "R6 not-taken target", redirect_pc, 32'hB000);
        chk(alloc_tag == 1, "R8 rewind", alloc_tag, 1);
        #1;
        step();
        chk(!flush_valid, "R5 one cycle", flush_valid, 0);
        alloc(0, 32'hE000, 32'hE004, 1);
        alloc(1, 32'hF000, 32'hF004, 2);
        resolve(2, 1);
        chk(flush_valid && flush_mask == 4'b0100, "R5 mask youngest", flush_mask, 4'b0100);
        chk(redirect_pc == 32'hF004, "R6 taken sequential", redirect_pc, 32'hF004);
        chk(busy_mask == 4'b0011, "R5 busy", busy_mask, 4'b0011);
    endtask

    task automatic t_priority();
        alloc_valid = 1; alloc_pred_taken = 1; alloc_target_pc = 32'h55; alloc_seq_pc = 32'h66;
        resolve_valid = 1; resolve_tag = 1; resolve_mispredict = 1;
        #1;
        chk(!alloc_ready, "R7 ready low", alloc_ready, 0);
        step();
        chk(busy_mask == 4'b0001 && flush_mask == 4'b0010, "R7 dropped", {flush_mask, busy_mask}, 8'h21);
        chk(alloc_tag == 1, "R8 after priority", alloc_tag, 1);
    endtask

    task automatic t_ignore();
        step();
        resolve(3, 1);
        chk(!flush_valid && busy_mask == 4'b0001, "R9 idle mispredict", {flush_valid, busy_mask}, 1);
        resolve(2, 0);
        chk(busy_mask == 4'b0001 && alloc_tag == 1, "R9 idle correct", {alloc_tag, busy_mask}, 6'h11);
    endtask

    task automatic t_wrap_age();
        resolve(0, 0);
        alloc(0, 32'h1100, 32'h1104, 1);
        alloc(0, 32'h2200, 32'h2204, 2);
        alloc(1, 32'h3300, 32'h3304, 3);
        alloc(0, 32'h4400, 32'h4404, 0);
        resolve(3, 1);
        chk(flush_valid && flush_mask == 4'b1001, "R5 wrap mask", flush_mask, 4'b1001);
        chk(busy_mask == 4'b0110, "R5 wrap busy", busy_mask, 4'b0110);
        chk(redirect_pc == 32'h3304, "R6 wrap taken", redirect_pc, 32'h3304);
    endtask

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_fill();
        t_ooo_free();
        t_mispredict();
        t_priority();
        t_ignore();
        t_wrap_age();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1-timeout actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule